// File: doc/BRIEF.md
# UART Line Break and Idle Monitor

This block watches a UART line next to a receiver. It measures line levels and does not decode frames. From the current word format it works out how many clock ticks one whole character occupies. It uses that frame time as the threshold for two line conditions.

A break is a low stretch that lasts at least one frame time. It is reported when the line returns high. An idle strobe fires for every whole frame time the line stays high. Each strobe comes with the tick at which its measurement started. When the receiver finishes a character, it signals this with a pulse and gives the age of that character in ticks. The monitor then re-anchors its idle measurement to the end of that character.

A free-running tick counter provides the time stamps. It starts at zero when reset is released and advances by one every clock.

Top module: `uart_line_monitor`

## Requirements
- R1: The frame time F in ticks is ceil(H * cfg_bit_ticks_i / 2), where H = 2*(1 + cfg_data_bits_i + cfg_parity_en_i) + cfg_stop_i. cfg_data_bits_i is the plain data bit count (5 to 9). cfg_stop_i counts stop bits in half-bit units: 0 is none, 1 is half, 2 is one, 3 is one and a half. F is at least 1 and saturates at the counter maximum. A configuration change takes effect one clock later.
- R2: The level that every check uses is line_i XOR cfg_invert_i.
- R3: A low run of N consecutive low samples with N >= F produces a break_o pulse. The pulse lasts one cycle and appears in the cycle after the first high sample that ends the run, never earlier.
- R4: A low run with N < F produces no break_o.
- R5: break_start_o, valid with break_o, holds the tick of the first low sample of the run.
- R6: After a first high sample at tick r, idle_o pulses for one cycle at ticks r+F, r+2F, and so on, while the line stays high. With each pulse, idle_start_o holds the start tick of the frame time that just completed (r, then r+F, ...).
- R7: Any low sample cancels the idle measurement, including any partial count. Counting restarts at the next high sample.
- R8: A frame_done_i pulse at tick c, given while the line is high, moves the idle reference to c - frame_age_i + F (frame_age_i < F). Idle pulses then follow at reference+F, reference+2F, and so on. No pulse from the earlier measurement appears after the frame_done_i pulse.
- R9: Reset clears all state. break_o and idle_o are low, and no idle pulse appears until a rising edge or a frame_done_i pulse, even if the line is high.
- R10: The low-run counter saturates, so a low run far longer than the counter range still reports a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one tick per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Serial line sample |
| cfg_invert_i | input | 1 | Invert line polarity |
| cfg_data_bits_i | input | 4 | Data bits per character |
| cfg_parity_en_i | input | 1 | Parity bit present |
| cfg_stop_i | input | 2 | Stop length in half bits |
| cfg_bit_ticks_i | input | BT_W | Bit width in ticks |
| frame_done_i | input | 1 | Receiver finished a character |
| frame_age_i | input | CNT_W | Ticks since that character's start edge |
| break_o | output | 1 | Break strobe |
| break_start_o | output | TS_W | Tick of the break's first low sample |
| idle_o | output | 1 | Idle strobe |
| idle_start_o | output | TS_W | Start tick of the completed idle frame time |

## Verification
The bench aims its break tests at low runs of F-1 and exactly F ticks. An off-by-one comparison would drop the break at F or raise one at F-1. It picks a word format whose half-bit product is odd, so a design that rounds down would shift every threshold by one. The bench checks idle pulse spacing over two or more periods, after a short high run cut by one low sample, and after a frame_done_i re-anchor. A design that kept its partial count, or failed to restart after a pulse, would drift from the expected ticks. A narrow-counter copy sees a low run much longer than its range, and a wrapping counter would miss that break.

// File: rtl/uart_line_mon_pkg.sv
package uart_line_mon_pkg;

  typedef enum logic [1:0] {
    STOP_NONE     = 2'd0,
    STOP_HALF     = 2'd1,
    STOP_ONE      = 2'd2,
    STOP_ONE_HALF = 2'd3
  } stop_len_e;

  localparam int unsigned HALF_W = 6;

  // frame length in half-bit units
  function automatic logic [HALF_W-1:0] frame_half_bits(
    input logic [3:0] data_bits,
    input logic       parity_en,
    input stop_len_e  stop
  );
    int unsigned h;
    h = 2 * (32'(data_bits) + 32'd1 + 32'(parity_en)) + 32'(stop);
    return HALF_W'(h);
  endfunction

endpackage

// File: rtl/ulm_frame_len.sv
module ulm_frame_len
  import uart_line_mon_pkg::*;
#(
  parameter int unsigned BT_W  = 16,
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic [1:0]       stop_i,
  input  logic [BT_W-1:0]  bit_ticks_i,
  output logic [CNT_W-1:0] frame_len_o
);

  localparam int unsigned PROD_W = BT_W + HALF_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [HALF_W-1:0] half;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] up;
  logic [CNT_W-1:0]  len_raw;
  logic [CNT_W-1:0]  len_d;

  assign half = frame_half_bits(data_bits_i, parity_en_i, stop_len_e'(stop_i));
  assign prod = PROD_W'(half) * PROD_W'(bit_ticks_i);
  assign up   = (prod + PROD_W'(1)) >> 1;

  generate
    if (PROD_W <= CNT_W) begin : g_fit
      assign len_raw = CNT_W'(up);
    end else begin : g_sat
      assign len_raw = (up > PROD_W'(CNT_MAX)) ? CNT_MAX : up[CNT_W-1:0];
    end
  endgenerate

  assign len_d = (len_raw == '0) ? CNT_W'(1) : len_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_len_o <= CNT_W'(1);
    else         frame_len_o <= len_d;
  end

endmodule

// File: rtl/ulm_break_trk.sv
module ulm_break_trk #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned TS_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             fall_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] frame_len_i,
  input  logic [TS_W-1:0]  ts_i,
  output logic             break_o,
  output logic [TS_W-1:0]  break_start_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             pend_q;
  logic [CNT_W-1:0] low_cnt_q;
  logic [TS_W-1:0]  t0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q        <= 1'b0;
      low_cnt_q     <= '0;
      t0_q          <= '0;
      break_o       <= 1'b0;
      break_start_o <= '0;
    end else begin
      break_o <= 1'b0;
      if (fall_i) begin
        pend_q    <= 1'b1;
        low_cnt_q <= CNT_W'(1);
        t0_q      <= ts_i;
      end else if (!lvl_i) begin
        if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + CNT_W'(1);
      end else if (rise_i) begin
        if (pend_q && (low_cnt_q >= frame_len_i)) begin
          break_o       <= 1'b1;
          break_start_o <= t0_q;
        end
        pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ulm_idle_trk.sv
module ulm_idle_trk #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned TS_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             rise_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] age_i,
  input  logic [CNT_W-1:0] frame_len_i,
  input  logic [TS_W-1:0]  ts_i,
  output logic             idle_o,
  output logic [TS_W-1:0]  idle_start_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             run_q;
  logic [CNT_W-1:0] defer_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TS_W-1:0]  ref_q;

  logic [CNT_W:0]   age_p1;
  logic [CNT_W-1:0] defer_d;
  logic [TS_W-1:0]  ref_done;
  logic             counting;
  logic [CNT_W-1:0] cnt_base;
  logic [CNT_W-1:0] cnt_nxt;
  logic [TS_W-1:0]  ref_cur;
  logic             hit;

  assign age_p1   = {1'b0, age_i} + (CNT_W+1)'(1);
  assign defer_d  = ({1'b0, frame_len_i} > age_p1) ? (frame_len_i - age_p1[CNT_W-1:0]) : '0;
  assign ref_done = ts_i - TS_W'(age_i) + TS_W'(frame_len_i);

  assign counting = rise_i || (run_q && (defer_q == '0));
  assign cnt_base = rise_i ? '0 : cnt_q;
  assign cnt_nxt  = (cnt_base != CNT_MAX) ? cnt_base + CNT_W'(1) : CNT_MAX;
  assign ref_cur  = rise_i ? ts_i : ref_q;
  assign hit      = counting && (cnt_nxt >= frame_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q        <= 1'b0;
      defer_q      <= '0;
      cnt_q        <= '0;
      ref_q        <= '0;
      idle_o       <= 1'b0;
      idle_start_o <= '0;
    end else begin
      idle_o <= 1'b0;
      if (!lvl_i) begin
        run_q   <= 1'b0;
        defer_q <= '0;
        cnt_q   <= '0;
      end else if (done_i) begin
        run_q   <= 1'b1;
        defer_q <= defer_d;
        cnt_q   <= '0;
        ref_q   <= ref_done;
      end else if (run_q && (defer_q != '0) && !rise_i) begin
        defer_q <= defer_q - CNT_W'(1);
      end else if (counting) begin
        run_q <= 1'b1;
        if (hit) begin
          idle_o       <= 1'b1;
          idle_start_o <= ref_cur;
          cnt_q        <= '0;
          ref_q        <= ts_i + TS_W'(1);
        end else begin
          cnt_q <= cnt_nxt;
          ref_q <= ref_cur;
        end
      end
    end
  end

endmodule

// File: rtl/uart_line_monitor.sv
module uart_line_monitor #(
  parameter int unsigned BT_W  = 16,
  parameter int unsigned CNT_W = 24,
  parameter int unsigned TS_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             cfg_invert_i,
  input  logic [3:0]       cfg_data_bits_i,
  input  logic             cfg_parity_en_i,
  input  logic [1:0]       cfg_stop_i,
  input  logic [BT_W-1:0]  cfg_bit_ticks_i,
  input  logic             frame_done_i,
  input  logic [CNT_W-1:0] frame_age_i,
  output logic             break_o,
  output logic [TS_W-1:0]  break_start_o,
  output logic             idle_o,
  output logic [TS_W-1:0]  idle_start_o
);

  logic             lvl;
  logic             lvl_q;
  logic             fall;
  logic             rise;
  logic [TS_W-1:0]  ts_q;
  logic [CNT_W-1:0] frame_len;

  assign lvl  = line_i ^ cfg_invert_i;
  assign fall = lvl_q & ~lvl;
  assign rise = ~lvl_q & lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b1;
      ts_q  <= '0;
    end else begin
      lvl_q <= lvl;
      ts_q  <= ts_q + TS_W'(1);
    end
  end

  ulm_frame_len #(.BT_W(BT_W), .CNT_W(CNT_W)) u_len (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .data_bits_i (cfg_data_bits_i),
    .parity_en_i (cfg_parity_en_i),
    .stop_i      (cfg_stop_i),
    .bit_ticks_i (cfg_bit_ticks_i),
    .frame_len_o (frame_len)
  );

  ulm_break_trk #(.CNT_W(CNT_W), .TS_W(TS_W)) u_brk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lvl_i         (lvl),
    .fall_i        (fall),
    .rise_i        (rise),
    .frame_len_i   (frame_len),
    .ts_i          (ts_q),
    .break_o       (break_o),
    .break_start_o (break_start_o)
  );

  ulm_idle_trk #(.CNT_W(CNT_W), .TS_W(TS_W)) u_idle (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lvl_i        (lvl),
    .rise_i       (rise),
    .done_i       (frame_done_i),
    .age_i        (frame_age_i),
    .frame_len_i  (frame_len),
    .ts_i         (ts_q),
    .idle_o       (idle_o),
    .idle_start_o (idle_start_o)
  );

endmodule

// File: rtl/ulm_checker.sv
module ulm_checker #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             line_i,
  input logic             cfg_invert_i,
  input logic             break_o,
  input logic             idle_o,
  input logic [CNT_W-1:0] frame_len_i
);

  logic        lvl;
  logic        lvl_d1;
  logic        lvl_d2;
  logic [31:0] low_run;
  logic [31:0] last_run;

  assign lvl = line_i ^ cfg_invert_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_d1   <= 1'b1;
      lvl_d2   <= 1'b1;
      low_run  <= '0;
      last_run <= '0;
    end else begin
      lvl_d1 <= lvl;
      lvl_d2 <= lvl_d1;
      if (!lvl) begin
        if (low_run != '1) low_run <= low_run + 32'd1;
      end else begin
        low_run <= '0;
        if (low_run != '0) last_run <= low_run;
      end
    end
  end

  AST_BREAK_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |-> (lvl_d1 && !lvl_d2)); // R3

  AST_BREAK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |=> !break_o); // R3

  AST_BREAK_MIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |-> (last_run >= 32'(frame_len_i))); // R4

  AST_IDLE_WHILE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> lvl_d1); // R6

  AST_FRAME_LEN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_len_i != '0); // R1

endmodule

bind uart_line_monitor ulm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .line_i       (line_i),
  .cfg_invert_i (cfg_invert_i),
  .break_o      (break_o),
  .idle_o       (idle_o),
  .frame_len_i  (frame_len)
);

// File: tb/uart_line_monitor_bench.sv
module uart_line_monitor_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line = 1'b1;
  logic        inv = 1'b0;
  logic [3:0]  db = 4'd8;
  logic        par = 1'b0;
  logic [1:0]  stop = 2'd2;
  logic [15:0] bt = 16'd4;
  logic        done = 1'b0;
  logic [23:0] age = '0;

  logic        brk, idl, brk_s, idl_s;
  logic [31:0] brk_ts, idl_ts, brk_ts_s, idl_ts_s;

  logic [31:0] cyc;
  bit          lvl_now = 1'b1;
  int          fl;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 32'd1;
  end

  uart_line_monitor u_uart_line_monitor (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .cfg_invert_i(inv),
    .cfg_data_bits_i(db), .cfg_parity_en_i(par), .cfg_stop_i(stop),
    .cfg_bit_ticks_i(bt), .frame_done_i(done), .frame_age_i(age),
    .break_o(brk), .break_start_o(brk_ts), .idle_o(idl), .idle_start_o(idl_ts)
  );

  uart_line_monitor #(.CNT_W(6)) u_uart_line_monitor_sat (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .cfg_invert_i(inv),
    .cfg_data_bits_i(db), .cfg_parity_en_i(par), .cfg_stop_i(stop),
    .cfg_bit_ticks_i(bt), .frame_done_i(done), .frame_age_i(age[5:0]),
    .break_o(brk_s), .break_start_o(brk_ts_s), .idle_o(idl_s), .idle_start_o(idl_ts_s)
  );

  function automatic int f_len(int d, int p, int s, int b, int cw);
    int h, l, mx;
    h  = 2 * (1 + d + p) + s;
    l  = (h * b + 1) / 2;
    mx = (1 << cw) - 1;
    if (l < 1) l = 1;
    if (l > mx) l = mx;
    return l;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_lvl(input bit v);
    lvl_now = v;
    line    = v ^ inv;
  endtask

  task automatic apply_cfg(input int d, input int p, input int s, input int b, input bit iv);
    db  = 4'(d);
    par = p[0];
    stop = 2'(s);
    bt  = 16'(b);
    inv = iv;
    line = lvl_now ^ inv;
    fl  = f_len(d, p, s, b, 24);
    repeat (3) @(negedge clk);
  endtask

  // R3 R4 R5: low run of n samples
  task automatic brk_run(input int n);
    longint t0;
    bit exp;
    set_lvl(1'b1);
    repeat (2) @(negedge clk);
    set_lvl(1'b0);
    t0 = longint'(cyc);
    repeat (n) @(negedge clk);
    set_lvl(1'b1);
    @(negedge clk);
    exp = (n >= fl);
    check(brk == exp, exp ? "R3 break after long low" : "R4 no break on short low", brk, exp);
    if (exp) check(longint'(brk_ts) == t0, "R5 break start tick", brk_ts, t0);
    @(negedge clk);
    check(brk == 1'b0, "R3 break single cycle", brk, 0);
  endtask

  task automatic idle_sample(input longint rf, input string req);
    longint d;
    bit exp;
    d   = longint'(cyc) - rf;
    exp = (d > 0) && ((d % fl) == 0);
    check(idl == exp, req, idl, exp);
    if (exp && idl) check(longint'(idl_ts) == rf + (d / fl - 1) * fl, "R6 idle start tick",
                          idl_ts, rf + (d / fl - 1) * fl);
  endtask

  task automatic idle_window(input longint rf, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      idle_sample(rf, req);
    end
  endtask

  task automatic idle_run();
    longint r;
    set_lvl(1'b0);
    repeat (2) @(negedge clk);
    set_lvl(1'b1);
    r = longint'(cyc);
    idle_window(r, 2 * fl + 2, "R6 idle period");
  endtask

  // R7: short high then one low sample
  task automatic cancel_run();
    longint r;
    set_lvl(1'b0);
    repeat (2) @(negedge clk);
    set_lvl(1'b1);
    r = longint'(cyc);
    idle_window(r, fl / 2, "R7 no idle before F");
    set_lvl(1'b0);
    @(negedge clk);
    check(idl == 1'b0, "R7 low cancels", idl, 0);
    set_lvl(1'b1);
    r = longint'(cyc);
    idle_window(r, 2 * fl + 1, "R7 idle after restart");
  endtask

  // R8: re-anchor by frame done, line high
  task automatic done_run(input int a);
    longint c, rf;
    done = 1'b1;
    age  = 24'(a);
    c    = longint'(cyc);
    rf   = c - a + fl;
    @(negedge clk);
    done = 1'b0;
    age  = '0;
    idle_sample(rf, "R8 frame done re-anchor");
    idle_window(rf, 2 * fl + 1, "R8 frame done re-anchor");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    fl = f_len(8, 0, 2, 4, 24);
    repeat (3) @(negedge clk);
    check(brk == 1'b0, "R9 break low in reset", brk, 0);
    check(idl == 1'b0, "R9 idle low in reset", idl, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 3 * fl; k++) begin
      @(negedge clk);
      check(idl == 1'b0, "R9 no idle before edge", idl, 0);
      check(brk == 1'b0, "R9 no break after reset", brk, 0);
    end

    apply_cfg(8, 0, 2, 4, 1'b0);   // F = 40
    brk_run(fl - 1);
    brk_run(fl);
    brk_run(fl + 7);
    idle_run();
    done_run(fl / 3);
    cancel_run();
    done_run(fl - 1);

    // R10: run far beyond a 6-bit counter
    set_lvl(1'b1);
    repeat (2) @(negedge clk);
    set_lvl(1'b0);
    repeat (150) @(negedge clk);
    set_lvl(1'b1);
    @(negedge clk);
    check(brk_s == 1'b1, "R10 saturated counter break", brk_s, 1);
    check(brk == 1'b1, "R10 long break", brk, 1);

    // R1: odd product rounds up, 13 half bits * 3 -> 20
    apply_cfg(5, 0, 1, 3, 1'b0);
    check(fl == 20, "R1 bench frame model", fl, 20);
    brk_run(19);
    brk_run(20);
    idle_run();

    // R2: inverted line
    apply_cfg(7, 1, 3, 2, 1'b1);
    brk_run(fl - 1);
    brk_run(fl);
    idle_run();
    apply_cfg(7, 1, 3, 2, 1'b0);

    for (int it = 0; it < 10; it++) begin
      int d, p, s, b;
      d = 5 + int'($urandom % 5);
      p = int'($urandom % 2);
      s = int'($urandom % 4);
      b = 1 + int'($urandom % 5);
      apply_cfg(d, p, s, b, 1'($urandom % 2));
      brk_run(fl - 1);
      brk_run(fl);
      brk_run(fl + int'($urandom % 6));
      idle_run();
      done_run(int'($urandom % fl));
      cancel_run();
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    finished = 1'b1;
    $finish;
  end

endmodule